// File: doc/BRIEF.md
# Masked Prefix Entry Match Array

This block keeps a small table of routing prefixes. Every slot holds an address word, a mask word and a valid bit. When a lookup key is presented, every slot checks whether the key agrees with its stored address on each bit position where the mask holds a one. Bits outside the mask are ignored. The outcome is one flag per slot, registered in the cycle after the key strobe. Next to the flags, the masks of all slots are captured at the same moment and exported, so that a separate resolver can pick the longest matching prefix.

Slots are written directly by index, with no ordering or pre-computation. Software keeps its own list of free indices. Adding a route takes one write of a valid entry to a free index. Removing a route takes one write with the valid bit low. Both complete in one cycle, whatever the table holds. Masks are meant to be left-aligned thermometer codes: ones run from the top bit down to the prefix length. A mask of all zeros matches every key.

Top module: `prefix_match_array`

## Requirements
- R1: After reset, every slot is invalid, `hit_vec` is all zeros, `hit_masks` is all zeros and `key_valid_out` is 0.
- R2: `key_valid_out` is 1 in exactly the cycle after a cycle with `key_valid` high, and 0 otherwise.
- R3: On a lookup, bit i of `hit_vec` is 1 exactly when slot i is valid and, for every bit position b where the slot's mask is 1, `key[b]` equals the stored `addr[b]`. Key bits at positions where the mask is 0 have no effect on the flag.
- R4: A valid slot whose mask is all zeros flags a hit for every key.
- R5: An invalid slot never flags a hit. Writing a slot with `wr_valid` low deletes it.
- R6: When a write and a lookup occur in the same cycle, the lookup result reflects the slot contents from before the write.
- R7: While `key_valid` is low, `hit_vec` and `hit_masks` keep their last captured values.
- R8: `hit_masks[32*i +: 32]` holds the mask of slot i as it was at lookup time, or zero if slot i was invalid then.
- R9: A write changes only the slot selected by `wr_idx`. Slots may be filled in any index order.
- R10: A valid slot with an all-ones mask flags a hit only for a key equal to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | 4 | Index of the slot to write |
| wr_addr | input | 32 | Address word to store |
| wr_mask | input | 32 | Prefix mask to store |
| wr_valid | input | 1 | Valid bit to store (0 deletes the slot) |
| key_valid | input | 1 | Lookup strobe |
| key | input | 32 | Lookup key |
| hit_vec | output | 16 | Per-slot match flags, registered |
| hit_masks | output | 512 | Per-slot masks captured with the flags, slot i at bits 32*i+31..32*i |
| key_valid_out | output | 1 | Marks the cycle in which a new lookup result is presented |

## Verification
The hardest case to reach from the ports is a lookup in the same cycle as a write that turns a slot from non-matching to matching. A lookup that follows the write a cycle later would hide a result drawn from the new contents. The bench drives both strobes on the same falling edge and checks that the flags and masks still show the old slot. A plain lookup afterwards confirms that the new entry has taken effect. The bench also sweeps every prefix length from 0 to 32. For each length it flips the lowest covered key bit and the highest uncovered key bit, which probes the mask boundary from both sides.

// File: rtl/pma_pkg.sv
package pma_pkg;
  parameter int KEY_W = 32;
  typedef logic [KEY_W-1:0] word_t;

  // A slot covers a key when no masked bit position differs.
  function automatic logic covers_key(input word_t k, input word_t a, input word_t m);
    return ~|((k ^ a) & m);
  endfunction

  // Masked view of a stored mask: invalid slots export zero.
  function automatic word_t export_mask(input logic v, input word_t m);
    return v ? m : '0;
  endfunction
endpackage

// File: rtl/pma_entry.sv
module pma_entry
  import pma_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SLOT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_addr,
  input  word_t            wr_mask,
  input  logic             wr_valid,
  input  word_t            key,
  output logic             ent_valid,
  output logic             ent_hit,
  output word_t            ent_mask
);
  logic  vld_q;
  word_t addr_q;
  word_t mask_q;
  logic  sel;

  assign sel = wr_en && (wr_idx == IDX_W'(SLOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      mask_q <= '0;
    end else if (sel) begin
      vld_q  <= wr_valid;
      addr_q <= wr_addr;
      mask_q <= wr_mask;
    end
  end

  assign ent_valid = vld_q;
  assign ent_hit   = vld_q && covers_key(key, addr_q, mask_q);
  assign ent_mask  = export_mask(vld_q, mask_q);

  // R9: a slot not addressed by the write port keeps its contents
  assert_untouched_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(vld_q) && $stable(addr_q) && $stable(mask_q)));
endmodule

// File: rtl/pma_capture.sv
module pma_capture
  import pma_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     key_valid,
  input  logic [ENTRIES-1:0]       hit_in,
  input  logic [ENTRIES*KEY_W-1:0] mask_in,
  output logic [ENTRIES-1:0]       hit_vec,
  output logic [ENTRIES*KEY_W-1:0] hit_masks,
  output logic                     key_valid_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_vec       <= '0;
      hit_masks     <= '0;
      key_valid_out <= 1'b0;
    end else begin
      key_valid_out <= key_valid;
      if (key_valid) begin
        hit_vec   <= hit_in;
        hit_masks <= mask_in;
      end
    end
  end

  // R2: result strobe follows the key strobe by one cycle
  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> key_valid_out);
  assert_strobe_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> !key_valid_out);
  // R7: captured results hold between lookups
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> ($stable(hit_vec) && $stable(hit_masks)));
endmodule

// File: rtl/prefix_match_array.sv
module prefix_match_array
  import pma_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [$clog2(ENTRIES)-1:0]       wr_idx,
  input  logic [KEY_W-1:0]                 wr_addr,
  input  logic [KEY_W-1:0]                 wr_mask,
  input  logic                             wr_valid,
  input  logic                             key_valid,
  input  logic [KEY_W-1:0]                 key,
  output logic [ENTRIES-1:0]               hit_vec,
  output logic [ENTRIES*KEY_W-1:0]         hit_masks,
  output logic                             key_valid_out
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]       slot_valid;
  logic [ENTRIES-1:0]       slot_hit;
  word_t                    slot_mask [ENTRIES];
  logic [ENTRIES*KEY_W-1:0] mask_bus;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    pma_entry #(.IDX_W(IDX_W), .SLOT(i)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_addr  (wr_addr),
      .wr_mask  (wr_mask),
      .wr_valid (wr_valid),
      .key      (key),
      .ent_valid(slot_valid[i]),
      .ent_hit  (slot_hit[i]),
      .ent_mask (slot_mask[i])
    );
    assign mask_bus[i*KEY_W +: KEY_W] = slot_mask[i];

    // R5: an invalid slot reports no hit after the lookup
    assert_invalid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && !slot_valid[i]) |=> !hit_vec[i]);
    // R4: a valid slot with an empty mask catches every key
    assert_empty_mask_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && slot_valid[i] && slot_mask[i] == '0) |=> hit_vec[i]);
  end

  pma_capture #(.ENTRIES(ENTRIES)) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_valid    (key_valid),
    .hit_in       (slot_hit),
    .mask_in      (mask_bus),
    .hit_vec      (hit_vec),
    .hit_masks    (hit_masks),
    .key_valid_out(key_valid_out)
  );
endmodule

// File: tb/tb_prefix_match_array.sv
module tb_prefix_match_array;
  localparam int N = 16;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_idx = '0;
  logic [W-1:0]   wr_addr = '0;
  logic [W-1:0]   wr_mask = '0;
  logic           wr_valid = 1'b0;
  logic           key_valid = 1'b0;
  logic [W-1:0]   key = '0;
  logic [N-1:0]   hit_vec;
  logic [N*W-1:0] hit_masks;
  logic           key_valid_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic         m_v [N];
  logic [W-1:0] m_a [N];
  logic [W-1:0] m_m [N];

  always #10 clk = ~clk;

  prefix_match_array dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .wr_valid(wr_valid), .key_valid(key_valid), .key(key),
    .hit_vec(hit_vec), .hit_masks(hit_masks), .key_valid_out(key_valid_out)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] thermo(input int len);
    logic [W-1:0] r = '0;
    for (int b = 0; b < len; b++) r[W-1-b] = 1'b1;
    return r;
  endfunction

  function automatic logic model_hit(input int i, input logic [W-1:0] k);
    if (!m_v[i]) return 1'b0;
    for (int b = 0; b < W; b++)
      if (m_m[i][b] && (k[b] != m_a[i][b])) return 1'b0;
    return 1'b1;
  endfunction

  // Compare captured results against the model; called at a falling edge.
  task automatic compare(input logic [W-1:0] k, input string req);
    logic [N-1:0] exp_v = '0;
    for (int i = 0; i < N; i++) exp_v[i] = model_hit(i, k);
    check(hit_vec == exp_v, req, W'(hit_vec), W'(exp_v));
    for (int i = 0; i < N; i++)
      check(hit_masks[i*W +: W] == (m_v[i] ? m_m[i] : '0), {req, " R8"},
            hit_masks[i*W +: W], m_v[i] ? m_m[i] : '0);
  endtask

  task automatic do_write(input int idx, input logic [W-1:0] a, input logic [W-1:0] m,
                          input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_addr = a; wr_mask = m; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
    m_v[idx] = v; m_a[idx] = a; m_m[idx] = m;
  endtask

  task automatic lookup(input logic [W-1:0] k, input string req);
    @(negedge clk);
    key_valid = 1'b1; key = k;
    @(negedge clk);
    key_valid = 1'b0;
    check(key_valid_out == 1'b1, "R2 strobe", W'(key_valid_out), 1);
    compare(k, req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a;
    logic [N-1:0] held_v;
    logic [N*W-1:0] held_m;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = '0; m_m[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(hit_vec == '0, "R1 hit_vec", W'(hit_vec), 0);
    check(hit_masks == '0, "R1 hit_masks", hit_masks[W-1:0], 0);
    check(key_valid_out == 1'b0, "R1 key_valid_out", W'(key_valid_out), 0);
    rst_n = 1'b1;
    lookup(32'hFFFF_FFFF, "R1 R5 empty table");

    // R3 R4 R10 R9: sweep every prefix length, slots filled in scrambled order
    for (int len = 0; len <= W; len++) begin
      int slot = (len * 7) % N;
      a = 32'hA5C3_1E69 ^ (32'(len) * 32'h0101_0107);
      do_write(slot, a, thermo(len), 1'b1);
      lookup(a, "R3 exact key");
      if (len > 0) lookup(a ^ (32'h1 << (W - len)), "R3 R10 covered bit flipped");
      if (len < W) lookup(a ^ (32'h1 << (W - 1 - len)), "R3 uncovered bit ignored");
      if (len == 0) lookup(~a, "R4 empty mask any key");
    end
    // R10: full-mask slot against a near key
    do_write(3, 32'h0A00_0001, 32'hFFFF_FFFF, 1'b1);
    lookup(32'h0A00_0001, "R10 full mask exact");
    lookup(32'h0A00_0003, "R10 full mask near miss");

    // R5: delete a slot and look up its old address
    do_write(3, 32'h0A00_0001, 32'hFFFF_FFFF, 1'b0);
    lookup(32'h0A00_0001, "R5 deleted slot");

    // R7: results hold while idle
    held_v = hit_vec; held_m = hit_masks;
    repeat (4) @(negedge clk);
    check(hit_vec == held_v, "R7 hit_vec hold", W'(hit_vec), W'(held_v));
    check(hit_masks == held_m, "R7 masks hold", hit_masks[W-1:0], held_m[W-1:0]);
    check(key_valid_out == 1'b0, "R2 idle strobe", W'(key_valid_out), 0);

    // R6: write and lookup in the same cycle see the old slot
    do_write(5, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd5; wr_addr = 32'hC0A8_0000; wr_mask = thermo(16); wr_valid = 1'b1;
    key_valid = 1'b1; key = 32'hC0A8_1234;
    @(negedge clk);
    wr_en = 1'b0; key_valid = 1'b0;
    compare(32'hC0A8_1234, "R6 old contents");
    m_v[5] = 1'b1; m_a[5] = 32'hC0A8_0000; m_m[5] = thermo(16);
    lookup(32'hC0A8_1234, "R6 new contents");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule